// File: doc/BRIEF.md
# Command Read Capture Bank

This block stores the bytes returned by a software-issued flash command when more than eight of them are expected. A command is opened with a one-cycle start strobe that carries a bank-enable flag and a 3-bit length code. Each received byte that falls within the command's length is counted. When the bank is enabled, the byte is written into a small byte memory at an address that starts at zero and wraps at the bank depth. Every counted byte also enters an eight-byte window, whether the bank is enabled or not. The window always shows the most recent eight bytes through two 32-bit read-data words.

Software reads the memory one byte at a time. It places an address on the readback port, pulses a trigger, waits for the busy flag to drop and then takes the returned byte. A long response can therefore be read back in full. A caller that only needs the tail of the response reads the window words directly.

Top module: `cmd_capture_bank`

## Requirements
- R1: After reset, `mb_busy` is 0, `mb_byte`, `rd_lo` and `rd_hi` are 0, and every bank location reads back as 0.
- R2: A `cmd_start` pulse clears the window to 0, restarts the bank write address at 0 and latches `cmd_bank_en` and `cmd_code`. A byte offered in the same cycle as `cmd_start`, or before the first `cmd_start` after reset, is ignored.
- R3: The number of bytes accepted per command is 2^(c+1), where c is `cmd_code`. With the bank enabled, c is clamped to 3, giving at most 16 bytes. With it disabled, c is clamped to 2, giving at most 8 bytes. Bytes beyond that count change neither the window nor the bank.
- R4: With the bank enabled, the n-th accepted byte of a command (counting from 0) is written to bank address n modulo DEPTH, so an overlong read overwrites the bank from address 0.
- R5: With the bank disabled, no bank location changes.
- R6: The window shifts only on accepted bytes. `rd_lo[7:0]` holds the newest byte, `rd_lo[15:8]` the one before it, and so on up to `rd_hi[31:24]`, which holds the eighth newest byte.
- R7: A trigger accepted while idle raises `mb_busy` after that clock edge. `mb_busy` falls after the second edge that follows. At that point `mb_byte` equals the bank content at the requested address, and it holds that value until the next access completes.
- R8: A trigger that arrives while `mb_busy` is 1 is ignored: it starts no access and does not change the address being served.
- R9: Address bits at and above log2(DEPTH) are ignored. The readback address is `mb_addr` modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that opens a command |
| cmd_bank_en | input | 1 | Bank enable for the command being opened |
| cmd_code | input | 3 | Length code; the command accepts 2^(code+1) bytes, clamped |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| mb_trigger | input | 1 | Starts a single-byte readback |
| mb_addr | input | 9 | Readback address |
| mb_busy | output | 1 | Readback in progress |
| mb_byte | output | 8 | Byte returned by the last completed readback |
| rd_lo | output | 32 | Newest four bytes of the window |
| rd_hi | output | 32 | Older four bytes of the window |

## Verification
The capture path is driven with three kinds of command:
- A short enabled command that stops before the bank fills. It separates correct start addressing from stale data in unwritten locations.
- A 16-byte command against a bench depth of 8. It shows the wrap: the bank must hold the second half of the command while the window holds the same eight bytes.
- Disabled commands whose lengths differ from the enabled ones. They show that the clamps are applied per enable state and that the bank is left untouched.

Each command is also fed more bytes than its length allows, and one of them has idle gaps between bytes. Together these separate counting accepted bytes from counting cycles. On the readback side, a back-to-back second trigger and an address with high bits set tell a port that latches once and masks the address apart from one that relaunches or indexes out of range.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int MB_ADDR_W   = 9;
    localparam int CODE_W      = 3;
    localparam int MAX_CODE_EN = 3;
    localparam int MAX_CODE_DIS = 2;
    localparam int WIN_BYTES   = 8;
    localparam int MAX_BYTES   = 2 ** (MAX_CODE_EN + 1);
    localparam int CNT_W       = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_FETCH = 2'd1,
        RB_DONE  = 2'd2
    } rb_state_e;
endpackage

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_start,
    input  logic                     cmd_bank_en,
    input  logic [CODE_W-1:0]        cmd_code,
    input  logic                     rx_valid,
    output logic                     accept,
    output logic                     we,
    output logic [$clog2(DEPTH)-1:0] waddr
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic             active;
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic [AW-1:0]    ptr;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic [CODE_W-1:0] eff_code;

    always_comb begin
        st_d   = st_q;
        accept = st_q.active && rx_valid && !cmd_start && (st_q.cnt < st_q.lim);
        if (cmd_bank_en) begin
            eff_code = (cmd_code > CODE_W'(MAX_CODE_EN)) ? CODE_W'(MAX_CODE_EN) : cmd_code;
        end else begin
            eff_code = (cmd_code > CODE_W'(MAX_CODE_DIS)) ? CODE_W'(MAX_CODE_DIS) : cmd_code;
        end
        if (cmd_start) begin
            st_d.active = 1'b1;
            st_d.en     = cmd_bank_en;
            st_d.cnt    = '0;
            st_d.lim    = CNT_W'(1) << (eff_code + CODE_W'(1));
            st_d.ptr    = '0;
        end else if (accept) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.ptr = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we    = accept && st_q.en;
    assign waddr = st_q.ptr;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);

    assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && we) |-> (waddr == AW'($past(waddr) + AW'(1))));
endmodule

// File: rtl/cap_window.sv
module cap_window
    import cap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   shift_en,
    input  logic [7:0]             din,
    output logic [WIN_BYTES*8-1:0] win
);
    logic [WIN_BYTES*8-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clr)           win_d = '0;
        else if (shift_en) win_d = {win_q[WIN_BYTES*8-9:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win = win_q;

    assert_window_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && !$past(clr)) |-> (win_q[15:8] == $past(win_q[7:0])));
endmodule

// File: rtl/cap_readback.sv
module cap_readback
    import cap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trigger,
    input  logic [MB_ADDR_W-1:0]     addr_in,
    input  logic [7:0]               mem_rdata,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     busy,
    output logic [7:0]               rd_byte
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        rb_state_e     state;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            RB_IDLE: if (trigger) begin
                st_d.state = RB_FETCH;
                st_d.addr  = addr_in[AW-1:0];
            end
            RB_FETCH: begin
                st_d.data  = mem_rdata;
                st_d.state = RB_DONE;
            end
            default: st_d.state = RB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: RB_IDLE, addr: '0, data: '0};
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.addr;
    assign busy    = (st_q.state != RB_IDLE);
    assign rd_byte = st_q.data;

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trigger) |=> $stable(st_q.addr));
endmodule

// File: rtl/cmd_capture_bank.sv
module cmd_capture_bank
    import cap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_start,
    input  logic                 cmd_bank_en,
    input  logic [CODE_W-1:0]    cmd_code,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 mb_trigger,
    input  logic [MB_ADDR_W-1:0] mb_addr,
    output logic                 mb_busy,
    output logic [7:0]           mb_byte,
    output logic [31:0]          rd_lo,
    output logic [31:0]          rd_hi
);
    localparam int AW = $clog2(DEPTH);

    logic          accept, we;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    bank_q [DEPTH];
    logic [WIN_BYTES*8-1:0] win;

    cap_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_bank_en(cmd_bank_en),
        .cmd_code(cmd_code), .rx_valid(rx_valid), .accept(accept), .we(we), .waddr(waddr)
    );

    cap_window u_win (
        .clk(clk), .rst_n(rst_n), .clr(cmd_start), .shift_en(accept),
        .din(rx_byte), .win(win)
    );

    cap_readback #(.DEPTH(DEPTH)) u_rb (
        .clk(clk), .rst_n(rst_n), .trigger(mb_trigger), .addr_in(mb_addr),
        .mem_rdata(bank_q[raddr]), .rd_addr(raddr), .busy(mb_busy), .rd_byte(mb_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
        end else if (we) begin
            bank_q[waddr] <= rx_byte;
        end
    end

    assign rd_lo = win[31:0];
    assign rd_hi = win[63:32];

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (rd_lo == 32'd0 && rd_hi == 32'd0));
endmodule

// File: tb/cmd_capture_bank_bench.sv
`timescale 1ns/1ps
module cmd_capture_bank_bench;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_bank_en = 1'b0;
    logic [2:0] cmd_code = '0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic mb_trigger = 1'b0;
    logic [8:0] mb_addr = '0;
    logic mb_busy;
    logic [7:0] mb_byte;
    logic [31:0] rd_lo, rd_hi;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    cmd_capture_bank #(.DEPTH(DEPTH)) u_cmd_capture_bank (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_bank_en(cmd_bank_en),
        .cmd_code(cmd_code), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mb_trigger(mb_trigger), .mb_addr(mb_addr), .mb_busy(mb_busy),
        .mb_byte(mb_byte), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    // behavioural reference model
    bit m_active, m_en, m_busy, m_ph;
    int m_cnt, m_lim, m_addr;
    logic [7:0] m_byte;
    logic [7:0] m_mem [int];
    logic [63:0] m_win;

    function automatic logic [7:0] mem_at(int a);
        return m_mem.exists(a) ? m_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_en = 0; m_busy = 0; m_ph = 0;
            m_cnt = 0; m_lim = 0; m_addr = 0; m_byte = 0; m_win = 0;
            m_mem.delete();
        end else begin
            if (m_busy) begin
                if (!m_ph) begin m_byte = mem_at(m_addr); m_ph = 1; end
                else m_busy = 0;
            end else if (mb_trigger) begin
                m_busy = 1; m_ph = 0; m_addr = int'(mb_addr) % DEPTH;
            end
            if (cmd_start) begin
                int c;
                c = int'(cmd_code);
                if (cmd_bank_en && c > 3) c = 3;
                if (!cmd_bank_en && c > 2) c = 2;
                m_active = 1; m_en = cmd_bank_en; m_cnt = 0; m_lim = 2 ** (c + 1); m_win = 0;
            end else if (m_active && rx_valid && m_cnt < m_lim) begin
                if (m_en) m_mem[m_cnt % DEPTH] = rx_byte;
                m_win = {m_win[55:0], rx_byte};
                m_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk({rd_hi, rd_lo} == m_win, "R6 window per-cycle", {rd_hi, rd_lo}, m_win);
            chk(mb_busy == m_busy, "R7 busy per-cycle", 64'(mb_busy), 64'(m_busy));
            chk(mb_byte == m_byte, "R7 byte per-cycle", 64'(mb_byte), 64'(m_byte));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic start_cmd(input bit en, input logic [2:0] code);
        cmd_start = 1; cmd_bank_en = en; cmd_code = code;
        tick();
        cmd_start = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_byte = b;
        tick();
        rx_valid = 0;
    endtask

    task automatic readback(input logic [8:0] a, input logic [7:0] exp, input string tag);
        mb_trigger = 1; mb_addr = a;
        tick();
        mb_trigger = 0;
        chk(mb_busy == 1'b1, "R7 busy after trigger", 64'(mb_busy), 64'd1);
        tick();
        chk(mb_busy == 1'b1, "R7 busy second cycle", 64'(mb_busy), 64'd1);
        tick();
        chk(mb_busy == 1'b0, "R7 busy fallen", 64'(mb_busy), 64'd0);
        chk(mb_byte == exp, tag, 64'(mb_byte), 64'(exp));
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(mb_busy == 0, "R1 busy reset", 64'(mb_busy), 0);
        chk(rd_lo == 0 && rd_hi == 0, "R1 window reset", {rd_hi, rd_lo}, 0);
        chk(mb_byte == 0, "R1 byte reset", 64'(mb_byte), 0);
        readback(9'd6, 8'h00, "R1 bank location reset");

        // R2 bytes before any command ignored
        push(8'h55);
        chk(rd_lo == 0, "R2 byte before start ignored", 64'(rd_lo), 0);

        // R3/R4 short enabled command, extra bytes ignored
        start_cmd(1, 3'd1);
        for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i));
        chk(rd_lo == 32'hA0A1A2A3 && rd_hi == 0, "R3 four bytes then ignore", {rd_hi, rd_lo}, {32'h0, 32'hA0A1A2A3});
        readback(9'd2, 8'hA2, "R4 address 2 of short command");
        readback(9'd4, 8'h00, "R3 extra byte not written");

        // R4/R6 16-byte command wraps depth 8, with gaps
        start_cmd(1, 3'd3);
        chk(rd_lo == 0 && rd_hi == 0, "R2 start clears window", {rd_hi, rd_lo}, 0);
        for (int i = 0; i < 20; i++) begin
            push(8'h10 + 8'(i));
            if (i % 3 == 0) tick();
        end
        chk(rd_hi == 32'h18191A1B && rd_lo == 32'h1C1D1E1F, "R6 last eight bytes", {rd_hi, rd_lo}, 64'h18191A1B1C1D1E1F);
        readback(9'd0, 8'h18, "R4 wrap overwrote address 0");
        readback(9'd7, 8'h1F, "R4 wrap address 7");

        // R3 clamp of code 7 with bank enabled
        start_cmd(1, 3'd7);
        for (int i = 0; i < 20; i++) push(8'h40 + 8'(i));
        chk(rd_hi == 32'h48494A4B && rd_lo == 32'h4C4D4E4F, "R3 clamp to 16 bytes", {rd_hi, rd_lo}, 64'h48494A4B4C4D4E4F);
        readback(9'd3, 8'h4B, "R3 clamped command address 3");

        // R5 disabled commands
        start_cmd(0, 3'd3);
        for (int i = 0; i < 12; i++) push(8'h80 + 8'(i));
        chk(rd_hi == 32'h80818283 && rd_lo == 32'h84858687, "R3 disabled clamp to 8", {rd_hi, rd_lo}, 64'h8081828384858687);
        readback(9'd3, 8'h4B, "R5 bank unchanged when disabled");
        start_cmd(0, 3'd0);
        for (int i = 0; i < 4; i++) push(8'h90 + 8'(i));
        chk(rd_lo == 32'h00009091 && rd_hi == 0, "R3 disabled code 0 two bytes", {rd_hi, rd_lo}, 64'h9091);
        readback(9'd1, 8'h49, "R5 bank unchanged after short disabled");

        // R8 trigger while busy ignored
        mb_trigger = 1; mb_addr = 9'd1;
        tick();
        mb_addr = 9'd6;
        tick();
        mb_trigger = 0;
        tick();
        chk(mb_busy == 0 && mb_byte == 8'h49, "R8 second trigger ignored", {mb_busy, mb_byte}, {1'b0, 8'h49});
        tick();
        chk(mb_busy == 0, "R8 no relaunch", 64'(mb_busy), 0);

        // R9 high address bits masked
        readback(9'h105, 8'h4D, "R9 address modulo depth");

        // R2 byte in the start cycle ignored
        cmd_start = 1; cmd_bank_en = 1; cmd_code = 3'd0; rx_valid = 1; rx_byte = 8'h77;
        tick();
        cmd_start = 0; rx_valid = 0;
        push(8'h21); push(8'h22); push(8'h23);
        chk(rd_lo == 32'h00002122, "R2 start-cycle byte ignored", 64'(rd_lo), 64'h2122);
        readback(9'd0, 8'h21, "R2 first byte at address 0");

        tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule